// File: doc/BRIEF.md
# Exception Entry and Return Mode Sequencer

This block keeps the processor's execution context for exception handling: whether the core runs in Thread or Handler mode, which of the two stack pointers (main or process) is active, and the number of the exception now being serviced. When an exception is taken, the block pushes an eight-word context frame through a single-port memory write interface. It then moves the core into Handler mode on the main stack, records the exception number and hands back the 32-bit return code that software keeps in the link register.

To return, software writes a return code to the program counter. The block checks the code. A legal code makes the block read the frame back in word order, release the frame space and restore the mode, stack choice, exception number and priority mask that were in force before the matching entry. An illegal code raises a one-cycle usage-fault pulse and changes nothing. Priority arbitration is done outside the block, and the register file sits behind the `frame_sel`/`frame_word` pair.

The sequencer is built around a three-state machine. `ST_RUN` is the resting state. It moves to `ST_PUSH` on an accepted exception and to `ST_POP` on a legal return. `ST_PUSH` returns to `ST_RUN` after its eighth write. `ST_POP` returns to `ST_RUN` after its eighth read. A small stack of saved exception numbers and priority masks makes nested returns restore the right values.

Top module: `exc_mode_seq`

## Requirements
- R1: After reset the block is in Thread mode with the main stack active, `ipsr` is 0, `pri_mask` and `faultmask` are 0, and `msp`/`psp` hold their reset parameters.
- R2: In Handler mode the main stack is always the active one. In Thread mode a `spsel_wr` pulse loads `spsel_val` into the stack choice (1 selects the process stack, 0 the main stack). A `spsel_wr` in Handler mode has no effect on `sp_psp`.
- R3: In `ST_RUN`, the block accepts an exception (`take_ack` high in the same cycle) when `take_req` is high, `take_num` is nonzero and the nesting store is not full. The stack active before entry drops by 32 bytes. Over the next eight cycles `wr_en` is high, `mem_addr` is the new stack pointer plus 4·i and `frame_sel` = i for i = 0..7. The selector order is 0=R0, 1=R1, 2=R2, 3=R3, 4=R12, 5=LR, 6=PC, 7=xPSR, so R0 lands at the lowest address.
- R4: In the cycle after the eighth write, the block is in Handler mode on the main stack, `ipsr` equals the accepted `take_num` and `pri_mask` equals the accepted `take_prio`.
- R5: During the eighth write `lr_wr` is high and `lr_val` carries ones in bits 31..4. The low nibble is 0001 if the block was in Handler mode before entry, 1001 if it was in Thread mode on the main stack, and 1101 if it was in Thread mode on the process stack.
- R6: A return starts only in `ST_RUN` in Handler mode, when `pc_wr` is high, bits 31..4 of `pc_val` are all ones and no exception is accepted in the same cycle. In Thread mode such a value is treated as an ordinary branch: no reads and no fault.
- R7: A legal return produces eight reads (`rd_en` high) on the consecutive cycles after the trigger, at the selected stack pointer plus 4·i. The process stack is used for nibble 1101 and the main stack otherwise. After the reads that stack pointer rises by 32.
- R8: In the cycle after the last read, the mode and stack choice follow the nibble, `ipsr` and `pri_mask` are restored to their values before the matching entry, and `faultmask` is 0. `fm_set` sets `faultmask`.
- R9: A return value with an undefined nibble, a Handler-return nibble (0001) when the outermost exception is active, or a Thread-return nibble when exceptions are nested gives a `usage_fault` pulse in the next cycle. No read follows, and mode and `ipsr` stay unchanged.
- R10: When the nesting store already holds `NEST_DEPTH` entries, `take_req` is not acknowledged, no write follows and `ipsr` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| take_req | input | 1 | Request to take an exception |
| take_num | input | NUM_W | Exception number of the request |
| take_prio | input | PRIO_W | Priority mask to apply while servicing it |
| take_ack | output | 1 | Request accepted this cycle |
| pc_wr | input | 1 | Program counter write strobe |
| pc_val | input | 32 | Value written to the program counter |
| spsel_wr | input | 1 | Stack-choice write strobe |
| spsel_val | input | 1 | Stack choice to write (1 = process stack) |
| fm_set | input | 1 | Set the fault mask |
| frame_sel | output | 3 | Frame slot being transferred |
| frame_word | input | 32 | Register value for the selected slot |
| wr_en | output | 1 | Frame write strobe |
| rd_en | output | 1 | Frame read strobe |
| mem_addr | output | AW | Byte address of the frame transfer |
| wr_data | output | 32 | Frame write data |
| lr_wr | output | 1 | Link register load strobe |
| lr_val | output | 32 | Return code for the link register |
| handler_mode | output | 1 | 1 in Handler mode |
| sp_psp | output | 1 | 1 when the process stack is active |
| ipsr | output | NUM_W | Active exception number, 0 in Thread mode |
| msp | output | AW | Main stack pointer |
| psp | output | AW | Process stack pointer |
| pri_mask | output | PRIO_W | Priority mask in force |
| faultmask | output | 1 | Fault mask |
| usage_fault | output | 1 | Illegal return code pulse |

## Verification
The hardest situations to reach are the returns that look legal but do not match the nesting: a Handler-return code while only the outermost exception is active, and a Thread-return code while two exceptions are stacked. A full nesting store is equally hard to reach. The bench builds the block with a nesting depth of two. It takes two exceptions back to back, offers a third, and sends mismatched return codes at both depths before unwinding legally. The return to the process stack is reached by first switching the stack choice in Thread mode, then entering and returning again.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
    localparam int unsigned FRAME_WORDS = 8;
    localparam int unsigned FRAME_SEL_W = $clog2(FRAME_WORDS);
    localparam int unsigned FRAME_BYTES = FRAME_WORDS * 4;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_PUSH = 2'd1,
        ST_POP  = 2'd2
    } seq_state_e;

    localparam logic [27:0] RET_CODE_HI  = '1;
    localparam logic [3:0]  NIB_HANDLER  = 4'b0001;
    localparam logic [3:0]  NIB_THR_MSP  = 4'b1001;
    localparam logic [3:0]  NIB_THR_PSP  = 4'b1101;
endpackage

// File: rtl/exc_ret_decode.sv
module exc_ret_decode
    import exc_seq_pkg::*;
(
    input  logic [31:0] val,
    output logic        magic,
    output logic        nib_ok,
    output logic        to_thread,
    output logic        use_psp
);
    logic [3:0] nib;

    always_comb begin
        nib       = val[3:0];
        magic     = (val[31:4] == RET_CODE_HI);
        to_thread = (nib == NIB_THR_MSP) || (nib == NIB_THR_PSP);
        use_psp   = (nib == NIB_THR_PSP);
        nib_ok    = to_thread || (nib == NIB_HANDLER);
    end
endmodule

// File: rtl/exc_nest_stack.sv
module exc_nest_stack #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         full
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [CW-1:0] ptr_q;
    logic [W-1:0]  mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (push && !full) begin
            ptr_q <= ptr_q + 1'b1;
        end else if (pop && (ptr_q != '0)) begin
            ptr_q <= ptr_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (push && !full && (ptr_q == CW'(i))) begin
                mem_q[i] <= din;
            end
        end
    end

    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ptr_q == CW'(i + 1)) begin
                top = mem_q[i];
            end
        end
        full = (ptr_q == CW'(DEPTH));
    end
endmodule

// File: rtl/exc_frame_walker.sv
module exc_frame_walker
    import exc_seq_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [AW-1:0]          base,
    output logic                   active,
    output logic [FRAME_SEL_W-1:0] idx,
    output logic [AW-1:0]          addr,
    output logic                   last
);
    localparam logic [FRAME_SEL_W-1:0] IDX_END = FRAME_SEL_W'(FRAME_WORDS - 1);

    logic                   act_q;
    logic [FRAME_SEL_W-1:0] idx_q;
    logic [AW-1:0]          base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            idx_q  <= '0;
            base_q <= '0;
        end else if (start) begin
            act_q  <= 1'b1;
            idx_q  <= '0;
            base_q <= base;
        end else if (act_q) begin
            if (idx_q == IDX_END) begin
                act_q <= 1'b0;
            end
            idx_q <= idx_q + 1'b1;
        end
    end

    always_comb begin
        active = act_q;
        idx    = idx_q;
        addr   = base_q + AW'({idx_q, 2'b00});
        last   = act_q && (idx_q == IDX_END);
    end
endmodule

// File: rtl/exc_mode_seq.sv
module exc_mode_seq
    import exc_seq_pkg::*;
#(
    parameter int unsigned    AW         = 32,
    parameter int unsigned    NUM_W      = 9,
    parameter int unsigned    PRIO_W     = 8,
    parameter int unsigned    NEST_DEPTH = 8,
    parameter logic [AW-1:0]  MSP_RST    = 32'h2000_1000,
    parameter logic [AW-1:0]  PSP_RST    = 32'h2000_0800
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   take_req,
    input  logic [NUM_W-1:0]       take_num,
    input  logic [PRIO_W-1:0]      take_prio,
    output logic                   take_ack,
    input  logic                   pc_wr,
    input  logic [31:0]            pc_val,
    input  logic                   spsel_wr,
    input  logic                   spsel_val,
    input  logic                   fm_set,
    output logic [FRAME_SEL_W-1:0] frame_sel,
    input  logic [31:0]            frame_word,
    output logic                   wr_en,
    output logic                   rd_en,
    output logic [AW-1:0]          mem_addr,
    output logic [31:0]            wr_data,
    output logic                   lr_wr,
    output logic [31:0]            lr_val,
    output logic                   handler_mode,
    output logic                   sp_psp,
    output logic [NUM_W-1:0]       ipsr,
    output logic [AW-1:0]          msp,
    output logic [AW-1:0]          psp,
    output logic [PRIO_W-1:0]      pri_mask,
    output logic                   faultmask,
    output logic                   usage_fault
);
    localparam int unsigned   NW        = NUM_W + PRIO_W;
    localparam logic [AW-1:0] FRAME_SZ  = AW'(FRAME_BYTES);

    seq_state_e state_q, state_d;

    logic              mode_q, spsel_q, fm_q, uf_q;
    logic [NUM_W-1:0]  ipsr_q, pend_num_q;
    logic [PRIO_W-1:0] prio_q, pend_prio_q;
    logic [AW-1:0]     msp_q, psp_q;
    logic [3:0]        ent_nib_q;
    logic              ret_thr_q, ret_psp_q;

    logic              dec_magic, dec_ok, dec_thr, dec_psp;
    logic [NW-1:0]     nest_top;
    logic              nest_full;
    logic [NUM_W-1:0]  top_num;
    logic [PRIO_W-1:0] top_prio;

    logic              in_run, take_go, ret_try, ret_ok, ret_bad;
    logic              cur_psp, walk_start, walk_act, walk_last;
    logic [AW-1:0]     walk_base, walk_addr;
    logic [FRAME_SEL_W-1:0] walk_idx;
    logic              push_done, pop_done;

    exc_ret_decode u_dec (
        .val       (pc_val),
        .magic     (dec_magic),
        .nib_ok    (dec_ok),
        .to_thread (dec_thr),
        .use_psp   (dec_psp)
    );

    exc_nest_stack #(.DEPTH(NEST_DEPTH), .W(NW)) u_nest (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_done),
        .pop   (pop_done),
        .din   ({ipsr_q, prio_q}),
        .top   (nest_top),
        .full  (nest_full)
    );

    exc_frame_walker #(.AW(AW)) u_walk (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (walk_start),
        .base   (walk_base),
        .active (walk_act),
        .idx    (walk_idx),
        .addr   (walk_addr),
        .last   (walk_last)
    );

    // Entry/return decisions taken in the resting state
    always_comb begin
        in_run     = (state_q == ST_RUN);
        top_num    = nest_top[NW-1:PRIO_W];
        top_prio   = nest_top[PRIO_W-1:0];
        cur_psp    = !mode_q && spsel_q;
        take_go    = in_run && take_req && (take_num != '0) && !nest_full;
        ret_try    = in_run && !take_go && pc_wr && dec_magic && mode_q;
        ret_ok     = ret_try && dec_ok && (dec_thr == (top_num == '0));
        ret_bad    = ret_try && !ret_ok;
        walk_start = take_go || ret_ok;
        if (take_go) begin
            walk_base = (cur_psp ? psp_q : msp_q) - FRAME_SZ;
        end else begin
            walk_base = dec_psp ? psp_q : msp_q;
        end
        push_done  = (state_q == ST_PUSH) && walk_last;
        pop_done   = (state_q == ST_POP) && walk_last;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (take_go) begin
                    state_d = ST_PUSH;
                end else if (ret_ok) begin
                    state_d = ST_POP;
                end
            end
            ST_PUSH: if (walk_last) state_d = ST_RUN;
            ST_POP:  if (walk_last) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Context registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q      <= 1'b0;
            spsel_q     <= 1'b0;
            fm_q        <= 1'b0;
            uf_q        <= 1'b0;
            ipsr_q      <= '0;
            prio_q      <= '0;
            pend_num_q  <= '0;
            pend_prio_q <= '0;
            msp_q       <= MSP_RST;
            psp_q       <= PSP_RST;
            ent_nib_q   <= NIB_THR_MSP;
            ret_thr_q   <= 1'b0;
            ret_psp_q   <= 1'b0;
        end else begin
            uf_q <= ret_bad;
            if (fm_set) begin
                fm_q <= 1'b1;
            end
            if (in_run && !take_go && spsel_wr && !mode_q) begin
                spsel_q <= spsel_val;
            end
            if (take_go) begin
                pend_num_q  <= take_num;
                pend_prio_q <= take_prio;
                if (cur_psp) begin
                    psp_q <= walk_base;
                end else begin
                    msp_q <= walk_base;
                end
                if (mode_q) begin
                    ent_nib_q <= NIB_HANDLER;
                end else if (spsel_q) begin
                    ent_nib_q <= NIB_THR_PSP;
                end else begin
                    ent_nib_q <= NIB_THR_MSP;
                end
            end
            if (ret_ok) begin
                ret_thr_q <= dec_thr;
                ret_psp_q <= dec_psp;
            end
            if (push_done) begin
                mode_q  <= 1'b1;
                spsel_q <= 1'b0;
                ipsr_q  <= pend_num_q;
                prio_q  <= pend_prio_q;
            end
            if (pop_done) begin
                mode_q  <= !ret_thr_q;
                spsel_q <= ret_psp_q;
                ipsr_q  <= top_num;
                prio_q  <= top_prio;
                fm_q    <= 1'b0;
                if (ret_psp_q) begin
                    psp_q <= psp_q + FRAME_SZ;
                end else begin
                    msp_q <= msp_q + FRAME_SZ;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        take_ack     = take_go;
        wr_en        = (state_q == ST_PUSH) && walk_act;
        rd_en        = (state_q == ST_POP) && walk_act;
        mem_addr     = walk_addr;
        frame_sel    = walk_idx;
        wr_data      = frame_word;
        lr_wr        = push_done;
        lr_val       = {RET_CODE_HI, ent_nib_q};
        handler_mode = mode_q;
        sp_psp       = spsel_q;
        ipsr         = ipsr_q;
        msp          = msp_q;
        psp          = psp_q;
        pri_mask     = prio_q;
        faultmask    = fm_q;
        usage_fault  = uf_q;
    end
endmodule

// File: rtl/exc_mode_seq_chk.sv
module exc_mode_seq_chk #(
    parameter int unsigned AW    = 32,
    parameter int unsigned NUM_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [AW-1:0]    mem_addr,
    input logic             lr_wr,
    input logic [31:0]      lr_val,
    input logic             handler_mode,
    input logic             sp_psp,
    input logic [NUM_W-1:0] ipsr,
    input logic             faultmask,
    input logic             usage_fault
);
    localparam logic [AW-1:0] STEP = AW'(4);

    p_msp_in_handler_r2: assert property (@(posedge clk) disable iff (!rst_n)
        handler_mode |-> !sp_psp);

    p_ipsr_matches_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        handler_mode |-> (ipsr != '0));

    p_thread_ipsr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !handler_mode |-> (ipsr == '0));

    p_push_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (mem_addr == $past(mem_addr) + STEP));

    p_pop_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (mem_addr == $past(mem_addr) + STEP));

    p_no_rw_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));

    p_ret_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lr_wr |-> ((lr_val[31:4] == '1) &&
                   ((lr_val[3:0] == 4'b0001) || (lr_val[3:0] == 4'b1001) ||
                    (lr_val[3:0] == 4'b1101))));

    p_fault_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        usage_fault |-> (!rd_en && $stable(ipsr) && $stable(handler_mode)));

    p_fm_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_en) |-> !faultmask);
endmodule

bind exc_mode_seq exc_mode_seq_chk #(.AW(AW), .NUM_W(NUM_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .mem_addr     (mem_addr),
    .lr_wr        (lr_wr),
    .lr_val       (lr_val),
    .handler_mode (handler_mode),
    .sp_psp       (sp_psp),
    .ipsr         (ipsr),
    .faultmask    (faultmask),
    .usage_fault  (usage_fault)
);

// File: tb/exc_mode_seq_test.sv
module exc_mode_seq_test;
    localparam logic [31:0] MSP0 = 32'h2000_1000;
    localparam logic [31:0] PSP0 = 32'h2000_0800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        take_req = 1'b0;
    logic [8:0]  take_num = '0;
    logic [7:0]  take_prio = '0;
    logic        take_ack;
    logic        pc_wr = 1'b0;
    logic [31:0] pc_val = '0;
    logic        spsel_wr = 1'b0;
    logic        spsel_val = 1'b0;
    logic        fm_set = 1'b0;
    logic [2:0]  frame_sel;
    logic [31:0] frame_word;
    logic        wr_en, rd_en, lr_wr, handler_mode, sp_psp, faultmask, usage_fault;
    logic [31:0] mem_addr, wr_data, lr_val, msp, psp;
    logic [8:0]  ipsr;
    logic [7:0]  pri_mask;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    always_comb frame_word = 32'hF00D_0000 | {29'b0, frame_sel};

    exc_mode_seq #(.NEST_DEPTH(2), .MSP_RST(MSP0), .PSP_RST(PSP0)) uut (
        .clk(clk), .rst_n(rst_n), .take_req(take_req), .take_num(take_num),
        .take_prio(take_prio), .take_ack(take_ack), .pc_wr(pc_wr), .pc_val(pc_val),
        .spsel_wr(spsel_wr), .spsel_val(spsel_val), .fm_set(fm_set),
        .frame_sel(frame_sel), .frame_word(frame_word), .wr_en(wr_en), .rd_en(rd_en),
        .mem_addr(mem_addr), .wr_data(wr_data), .lr_wr(lr_wr), .lr_val(lr_val),
        .handler_mode(handler_mode), .sp_psp(sp_psp), .ipsr(ipsr), .msp(msp),
        .psp(psp), .pri_mask(pri_mask), .faultmask(faultmask), .usage_fault(usage_fault)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_entry(input logic [8:0] num, input logic [7:0] prio,
                            input logic [31:0] base, input logic [3:0] nib);
        @(negedge clk);
        take_req = 1'b1; take_num = num; take_prio = prio;
        #1 chk("R3 take_ack", 32'(take_ack), 1);
        @(posedge clk);
        @(negedge clk);
        take_req = 1'b0;
        for (int i = 0; i < 8; i++) begin
            chk("R3 wr_en", 32'(wr_en), 1);
            chk("R3 addr", mem_addr, base + 32'(4 * i));
            chk("R3 order", wr_data, 32'hF00D_0000 + 32'(i));
            if (i == 7) begin
                chk("R5 lr_wr", 32'(lr_wr), 1);
                chk("R5 code", lr_val, {28'hFFFFFFF, nib});
            end
            @(negedge clk);
        end
        chk("R3 writes end", 32'(wr_en), 0);
        chk("R4 handler", 32'(handler_mode), 1);
        chk("R4 msp active", 32'(sp_psp), 0);
        chk("R4 ipsr", 32'(ipsr), 32'(num));
        chk("R4 mask", 32'(pri_mask), 32'(prio));
    endtask

    task automatic do_return(input logic [31:0] code, input logic [31:0] base);
        @(negedge clk);
        pc_wr = 1'b1; pc_val = code;
        @(posedge clk);
        @(negedge clk);
        pc_wr = 1'b0;
        for (int i = 0; i < 8; i++) begin
            chk("R7 rd_en", 32'(rd_en), 1);
            chk("R7 addr", mem_addr, base + 32'(4 * i));
            @(negedge clk);
        end
        chk("R7 reads end", 32'(rd_en), 0);
        chk("R8 faultmask", 32'(faultmask), 0);
    endtask

    task automatic bad_return(input logic [31:0] code, input logic [8:0] exp_ipsr);
        @(negedge clk);
        pc_wr = 1'b1; pc_val = code;
        @(negedge clk);
        pc_wr = 1'b0;
        chk("R9 fault pulse", 32'(usage_fault), 1);
        chk("R9 no read", 32'(rd_en), 0);
        @(negedge clk);
        chk("R9 pulse ends", 32'(usage_fault), 0);
        chk("R9 no read later", 32'(rd_en), 0);
        chk("R9 ipsr kept", 32'(ipsr), 32'(exp_ipsr));
        chk("R9 mode kept", 32'(handler_mode), 1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 mode", 32'(handler_mode), 0);
        chk("R1 stack", 32'(sp_psp), 0);
        chk("R1 ipsr", 32'(ipsr), 0);
        chk("R1 msp", msp, MSP0);
        chk("R1 psp", psp, PSP0);
        chk("R1 mask", 32'(pri_mask), 0);
        chk("R1 faultmask", 32'(faultmask), 0);
        chk("R1 idle", 32'(wr_en | rd_en), 0);
    endtask

    task automatic t_fm_set;
        @(negedge clk); fm_set = 1'b1;
        @(negedge clk); fm_set = 1'b0;
        chk("R8 fm_set", 32'(faultmask), 1);
    endtask

    task automatic t_spsel_handler;
        @(negedge clk); spsel_wr = 1'b1; spsel_val = 1'b1;
        @(negedge clk); spsel_wr = 1'b0;
        chk("R2 handler write ignored", 32'(sp_psp), 0);
    endtask

    task automatic t_nest_full;
        @(negedge clk);
        take_req = 1'b1; take_num = 9'd30; take_prio = 8'h05;
        #1 chk("R10 no ack", 32'(take_ack), 0);
        @(negedge clk);
        take_req = 1'b0;
        chk("R10 no write", 32'(wr_en), 0);
        @(negedge clk);
        chk("R10 ipsr kept", 32'(ipsr), 20);
    endtask

    task automatic t_thread_magic;
        @(negedge clk); pc_wr = 1'b1; pc_val = 32'hFFFF_FFF9;
        @(negedge clk); pc_wr = 1'b0;
        chk("R6 no read in thread", 32'(rd_en), 0);
        chk("R6 no fault in thread", 32'(usage_fault), 0);
        @(negedge clk);
        chk("R6 still quiet", 32'(rd_en | usage_fault), 0);
    endtask

    task automatic t_spsel_thread;
        @(negedge clk); spsel_wr = 1'b1; spsel_val = 1'b1;
        @(negedge clk); spsel_wr = 1'b0;
        chk("R2 thread select psp", 32'(sp_psp), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_fm_set();
        do_entry(9'd16, 8'h40, MSP0 - 32, 4'b1001);
        chk("R3 msp dropped", msp, MSP0 - 32);
        bad_return(32'hFFFF_FFF5, 9'd16);
        bad_return(32'hFFFF_FFF1, 9'd16);
        t_spsel_handler();
        do_entry(9'd20, 8'h20, MSP0 - 64, 4'b0001);
        t_nest_full();
        bad_return(32'hFFFF_FFF9, 9'd20);
        do_return(32'hFFFF_FFF1, MSP0 - 64);
        chk("R8 still handler", 32'(handler_mode), 1);
        chk("R8 ipsr restored", 32'(ipsr), 16);
        chk("R8 mask restored", 32'(pri_mask), 32'h40);
        chk("R7 msp raised", msp, MSP0 - 32);
        do_return(32'hFFFF_FFF9, MSP0 - 32);
        chk("R8 thread", 32'(handler_mode), 0);
        chk("R8 ipsr zero", 32'(ipsr), 0);
        chk("R8 mask zero", 32'(pri_mask), 0);
        chk("R8 msp stack", 32'(sp_psp), 0);
        chk("R7 msp back", msp, MSP0);
        t_thread_magic();
        t_spsel_thread();
        do_entry(9'd17, 8'h10, PSP0 - 32, 4'b1101);
        chk("R3 psp dropped", psp, PSP0 - 32);
        chk("R3 msp untouched", msp, MSP0);
        do_return(32'hFFFF_FFFD, PSP0 - 32);
        chk("R8 thread psp", 32'(sp_psp), 1);
        chk("R8 thread mode", 32'(handler_mode), 0);
        chk("R7 psp back", psp, PSP0);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule